// File: doc/BRIEF.md
# Pin Function Override Arbiter

This block decides who drives each of the 24 pins of a small microcontroller's three 8-bit I/O ports. The candidates are the GPIO logic, a peripheral, the ADC (analog input), the debug interface, the I2S interface, a radio status output and the low-frequency crystal oscillator (analog). For every pin the block produces the final output value, the output enable, an analog-mode flag and a 3-bit owner code. The pad electronics and the peripherals themselves are outside the block.

The choice follows a fixed layered precedence rather than a plain select-driven multiplexer. The crystal control claims its two pins whatever else is set. Debug comes next. I2S overrides every remaining function, even on pins configured as GPIO. Radio status outputs force their pins to be outputs. The ADC pin configuration beats the port function select. Only then does the select bit choose between the winning peripheral and plain GPIO. Pin k of port p has flat index 8*p+k.

There is no streaming data path. Every input and output is a plain level signal, so the block needs no valid/ready handshake and applies no back-pressure. With `REG_OUT=1` (the default) all results pass through one register stage, which aligns them to `clk`.

Top module: `pin_func_arbiter`

## Requirements
- R1: With REG_OUT=1, reset drives every output low. Every owner code is then 0 (GPIO) and `adc_trig` is 0. After reset, each output reflects the inputs that were present at the previous rising clock edge.
- R2: A pin with no override and its select bit clear is owned by GPIO (owner code 0). Its output enable equals its direction bit and its output value equals its data bit. The owner codes are: GPIO 0, peripheral 1, ADC 2, debug 3, I2S 4, radio 5, crystal 6.
- R3: A pin with no override and its select bit set is owned by a peripheral (code 1). It follows the output value and enable of the requesting peripheral. If neither peripheral requests the pin, its enable and value are both 0.
- R4: On port-1 pins (indices 8..15), when both peripherals request a pin, peripheral B wins if `prio_b_p1` is 1 and peripheral A wins otherwise. On all other pins, A wins whenever both request.
- R5: A set bit n of `adc_ana_en` makes port-0 pin n (index n) analog (code 2), whatever its select bit says.
- R6: While `dbg_active` is 1, pin 17 carries debug data with enable `dbg_dd_oe` and value `dbg_dd_out`, and pin 18 carries the debug clock as an input. Both pins use code 3, and their select and direction bits have no effect.
- R7: While `i2s_en` is 1, I2S owns four pins (code 4). These are indices 2..5 when `i2s_loc` is 0 and indices 12..15 when it is 1, assigned in rising index order to SCK, WS, RX and TX. RX is an input (enable 0, value 0). I2S beats peripheral, ADC, radio and GPIO, even when the select bit is clear.
- R8: A non-zero `RCFG_W`-bit field k of `radio_cfg` makes pin 13+k an output of `radio_stat[k]` (code 5), for k = 0..2. While `i2s_en` is 1 the radio configuration has no effect.
- R9: While `osc32_run` is 0, pins 19 and 20 are in crystal analog mode (code 6) whatever their other configuration.
- R10: A pin has its analog flag set only when its owner is ADC or crystal. Every analog pin has enable 0 and value 0.
- R11: `adc_trig` equals `trig_pin_in` when `adc_trig_en` is 1 and pin 16 has both its select and direction bits at 0. Otherwise `adc_trig` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_dir | input | 24 | GPIO direction bits, 1 = output |
| gpio_sel | input | 24 | Function select bits, 1 = peripheral |
| gpio_dout | input | 24 | GPIO output data |
| per_a_req | input | 24 | Peripheral A claims the pin |
| per_a_out | input | 24 | Peripheral A output value |
| per_a_oe | input | 24 | Peripheral A output enable |
| per_b_req | input | 24 | Peripheral B claims the pin |
| per_b_out | input | 24 | Peripheral B output value |
| per_b_oe | input | 24 | Peripheral B output enable |
| prio_b_p1 | input | 1 | Peripheral B wins on port 1 |
| adc_ana_en | input | 8 | Per-channel analog enable for port 0 |
| dbg_active | input | 1 | Debug interface active |
| dbg_dd_oe | input | 1 | Debug drives the data pin |
| dbg_dd_out | input | 1 | Debug data value |
| i2s_en | input | 1 | I2S enable |
| i2s_loc | input | 1 | I2S location, 0 = pins 2..5, 1 = pins 12..15 |
| i2s_sck_out | input | 1 | I2S serial clock value |
| i2s_sck_oe | input | 1 | I2S serial clock enable |
| i2s_ws_out | input | 1 | I2S word select value |
| i2s_ws_oe | input | 1 | I2S word select enable |
| i2s_tx_out | input | 1 | I2S serial data out value |
| i2s_tx_oe | input | 1 | I2S serial data out enable |
| radio_cfg | input | 3*RCFG_W | Radio status output config, one field per pin 13..15 |
| radio_stat | input | 3 | Radio status values |
| osc32_run | input | 1 | Low-frequency oscillator control, 0 = crystal pins analog |
| adc_trig_en | input | 1 | Use pin 16 as external ADC trigger |
| trig_pin_in | input | 1 | Sampled pad value of pin 16 |
| pin_out | output | 24 | Final output value per pin |
| pin_oe | output | 24 | Final output enable per pin |
| pin_ana | output | 24 | Analog-mode flag per pin |
| pin_owner | output | 72 | Owner code per pin, 3 bits each, pin i at bits 3i+2..3i |
| adc_trig | output | 1 | External ADC trigger |

## Verification
The block holds no state apart from the optional output register, so a wrong precedence or a wrong pin mapping appears in the owner code, enable or value of the affected pin. With the register stage it shows one clock after the inputs that expose it. A stale or mis-aligned register shows up as an output that lags a changed input by a cycle. Random mixes of the override controls place most pins under several competing claims at once. Directed cases pin down the tie-breaks: I2S against radio, the port-1 priority bit, and the crystal pins under full configuration.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int PORT_W   = 8;
  localparam int NPORT    = 3;
  localparam int NPIN     = PORT_W * NPORT;
  localparam int ADC_CH   = PORT_W;
  localparam int OWN_W    = 3;
  localparam int I2S_NSLOT = 4;
  localparam int I2S_BASE0 = 2;
  localparam int I2S_BASE1 = PORT_W + 4;
  localparam int RADIO_N   = 3;
  localparam int RADIO_BASE = PORT_W + 5;
  localparam int PRIO_LO  = PORT_W;
  localparam int PRIO_HI  = 2 * PORT_W - 1;
  localparam int PIN_TRIG = 2 * PORT_W;
  localparam int PIN_DD   = 2 * PORT_W + 1;
  localparam int PIN_DC   = 2 * PORT_W + 2;
  localparam int PIN_XT0  = 2 * PORT_W + 3;
  localparam int PIN_XT1  = 2 * PORT_W + 4;
  localparam int I2S_RX_SLOT = 2;

  typedef enum logic [OWN_W-1:0] {
    OWN_GPIO   = 3'd0,
    OWN_PERIPH = 3'd1,
    OWN_ADC    = 3'd2,
    OWN_DEBUG  = 3'd3,
    OWN_I2S    = 3'd4,
    OWN_RADIO  = 3'd5,
    OWN_XTAL   = 3'd6
  } owner_e;

  typedef struct packed {
    owner_e owner;
    logic   oe;
    logic   out;
    logic   ana;
  } pin_res_t;

  localparam int RES_W = $bits(pin_res_t);
endpackage

// File: rtl/pm_periph_pick.sv
module pm_periph_pick #(
  parameter int NPIN    = 24,
  parameter int PRIO_LO = 8,
  parameter int PRIO_HI = 15
) (
  input  logic [NPIN-1:0] a_req,
  input  logic [NPIN-1:0] a_out,
  input  logic [NPIN-1:0] a_oe,
  input  logic [NPIN-1:0] b_req,
  input  logic [NPIN-1:0] b_out,
  input  logic [NPIN-1:0] b_oe,
  input  logic            prio_b,
  output logic [NPIN-1:0] p_out,
  output logic [NPIN-1:0] p_oe
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic take_b;
    if (i >= PRIO_LO && i <= PRIO_HI) begin : g_prio
      assign take_b = b_req[i] & (prio_b | ~a_req[i]);
    end else begin : g_fixed
      assign take_b = b_req[i] & ~a_req[i];
    end
    always_comb begin
      if (take_b) begin
        p_out[i] = b_out[i];
        p_oe[i]  = b_oe[i];
      end else if (a_req[i]) begin
        p_out[i] = a_out[i];
        p_oe[i]  = a_oe[i];
      end else begin
        p_out[i] = 1'b0;
        p_oe[i]  = 1'b0;
      end
    end
  end
endmodule

// File: rtl/pm_pin_resolve.sv
module pm_pin_resolve
  import pm_pkg::*;
(
  input  logic     g_dir,
  input  logic     g_sel,
  input  logic     g_dout,
  input  logic     per_out,
  input  logic     per_oe,
  input  logic     adc_hit,
  input  logic     dbg_hit,
  input  logic     dbg_oe,
  input  logic     dbg_out,
  input  logic     i2s_hit,
  input  logic     i2s_oe,
  input  logic     i2s_out,
  input  logic     radio_hit,
  input  logic     radio_val,
  input  logic     xtal_hit,
  output pin_res_t res
);
  always_comb begin
    if (xtal_hit)       res = '{OWN_XTAL,   1'b0,    1'b0,      1'b1};
    else if (dbg_hit)   res = '{OWN_DEBUG,  dbg_oe,  dbg_out,   1'b0};
    else if (i2s_hit)   res = '{OWN_I2S,    i2s_oe,  i2s_out,   1'b0};
    else if (radio_hit) res = '{OWN_RADIO,  1'b1,    radio_val, 1'b0};
    else if (adc_hit)   res = '{OWN_ADC,    1'b0,    1'b0,      1'b1};
    else if (g_sel)     res = '{OWN_PERIPH, per_oe,  per_out,   1'b0};
    else                res = '{OWN_GPIO,   g_dir,   g_dout,    1'b0};
  end
endmodule

// File: rtl/pm_out_stage.sv
module pm_out_stage #(
  parameter int W   = 8,
  parameter bit REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    // R1: each output carries the inputs of the previous edge
    p_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> q == $past(d));
  end else begin : g_pass
    assign q = d;
  end
endmodule

// File: rtl/pin_func_arbiter.sv
module pin_func_arbiter
  import pm_pkg::*;
#(
  parameter bit REG_OUT = 1'b1,
  parameter int RCFG_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPIN-1:0]         gpio_dir,
  input  logic [NPIN-1:0]         gpio_sel,
  input  logic [NPIN-1:0]         gpio_dout,
  input  logic [NPIN-1:0]         per_a_req,
  input  logic [NPIN-1:0]         per_a_out,
  input  logic [NPIN-1:0]         per_a_oe,
  input  logic [NPIN-1:0]         per_b_req,
  input  logic [NPIN-1:0]         per_b_out,
  input  logic [NPIN-1:0]         per_b_oe,
  input  logic                    prio_b_p1,
  input  logic [ADC_CH-1:0]       adc_ana_en,
  input  logic                    dbg_active,
  input  logic                    dbg_dd_oe,
  input  logic                    dbg_dd_out,
  input  logic                    i2s_en,
  input  logic                    i2s_loc,
  input  logic                    i2s_sck_out,
  input  logic                    i2s_sck_oe,
  input  logic                    i2s_ws_out,
  input  logic                    i2s_ws_oe,
  input  logic                    i2s_tx_out,
  input  logic                    i2s_tx_oe,
  input  logic [RADIO_N*RCFG_W-1:0] radio_cfg,
  input  logic [RADIO_N-1:0]      radio_stat,
  input  logic                    osc32_run,
  input  logic                    adc_trig_en,
  input  logic                    trig_pin_in,
  output logic [NPIN-1:0]         pin_out,
  output logic [NPIN-1:0]         pin_oe,
  output logic [NPIN-1:0]         pin_ana,
  output logic [NPIN*OWN_W-1:0]   pin_owner,
  output logic                    adc_trig
);
  localparam int STAGE_W = NPIN * RES_W + 1;

  logic [NPIN-1:0] per_out, per_oe;
  logic [I2S_NSLOT-1:0] slot_out, slot_oe;
  pin_res_t res [NPIN];
  logic [STAGE_W-1:0] stage_d, stage_q;
  logic trig_c;

  assign slot_out = {i2s_tx_out, 1'b0, i2s_ws_out, i2s_sck_out};
  assign slot_oe  = {i2s_tx_oe,  1'b0, i2s_ws_oe,  i2s_sck_oe};

  pm_periph_pick #(.NPIN(NPIN), .PRIO_LO(PRIO_LO), .PRIO_HI(PRIO_HI)) i_pick (
    .a_req(per_a_req), .a_out(per_a_out), .a_oe(per_a_oe),
    .b_req(per_b_req), .b_out(per_b_out), .b_oe(per_b_oe),
    .prio_b(prio_b_p1), .p_out(per_out), .p_oe(per_oe)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic adc_hit, dbg_hit, dbg_oe, dbg_out;
    logic i2s_hit, i2s_oe, i2s_out;
    logic radio_hit, radio_val, xtal_hit;

    if (i < ADC_CH) begin : g_adc
      assign adc_hit = adc_ana_en[i];
    end else begin : g_noadc
      assign adc_hit = 1'b0;
    end

    if (i == PIN_DD) begin : g_dd
      assign dbg_hit = dbg_active;
      assign dbg_oe  = dbg_dd_oe;
      assign dbg_out = dbg_dd_out;
    end else if (i == PIN_DC) begin : g_dc
      assign dbg_hit = dbg_active;
      assign dbg_oe  = 1'b0;
      assign dbg_out = 1'b0;
    end else begin : g_nodbg
      assign dbg_hit = 1'b0;
      assign dbg_oe  = 1'b0;
      assign dbg_out = 1'b0;
    end

    if (i >= I2S_BASE0 && i < I2S_BASE0 + I2S_NSLOT) begin : g_i2s0
      assign i2s_hit = i2s_en & ~i2s_loc;
      assign i2s_oe  = slot_oe[i - I2S_BASE0];
      assign i2s_out = slot_out[i - I2S_BASE0];
    end else if (i >= I2S_BASE1 && i < I2S_BASE1 + I2S_NSLOT) begin : g_i2s1
      assign i2s_hit = i2s_en & i2s_loc;
      assign i2s_oe  = slot_oe[i - I2S_BASE1];
      assign i2s_out = slot_out[i - I2S_BASE1];
    end else begin : g_noi2s
      assign i2s_hit = 1'b0;
      assign i2s_oe  = 1'b0;
      assign i2s_out = 1'b0;
    end

    if (i >= RADIO_BASE && i < RADIO_BASE + RADIO_N) begin : g_radio
      assign radio_hit = (|radio_cfg[(i-RADIO_BASE)*RCFG_W +: RCFG_W]) & ~i2s_en;
      assign radio_val = radio_stat[i - RADIO_BASE];
    end else begin : g_noradio
      assign radio_hit = 1'b0;
      assign radio_val = 1'b0;
    end

    if (i == PIN_XT0 || i == PIN_XT1) begin : g_xt
      assign xtal_hit = ~osc32_run;
    end else begin : g_noxt
      assign xtal_hit = 1'b0;
    end

    pm_pin_resolve i_res (
      .g_dir(gpio_dir[i]), .g_sel(gpio_sel[i]), .g_dout(gpio_dout[i]),
      .per_out(per_out[i]), .per_oe(per_oe[i]),
      .adc_hit(adc_hit),
      .dbg_hit(dbg_hit), .dbg_oe(dbg_oe), .dbg_out(dbg_out),
      .i2s_hit(i2s_hit), .i2s_oe(i2s_oe), .i2s_out(i2s_out),
      .radio_hit(radio_hit), .radio_val(radio_val),
      .xtal_hit(xtal_hit),
      .res(res[i])
    );

    assign stage_d[i*RES_W +: RES_W] = res[i];
    assign pin_owner[i*OWN_W +: OWN_W] = stage_q[i*RES_W + 3 +: OWN_W];
    assign pin_oe[i]  = stage_q[i*RES_W + 2];
    assign pin_out[i] = stage_q[i*RES_W + 1];
    assign pin_ana[i] = stage_q[i*RES_W];

    // R10: analog pins never drive
    p_ana_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      res[i].ana |-> (!res[i].oe && !res[i].out &&
        (res[i].owner == OWN_ADC || res[i].owner == OWN_XTAL)));
    // R8: I2S enable blocks every radio status output
    p_radio_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      i2s_en |-> res[i].owner != OWN_RADIO);
  end

  assign trig_c = adc_trig_en & ~gpio_sel[PIN_TRIG] & ~gpio_dir[PIN_TRIG] & trig_pin_in;
  assign stage_d[STAGE_W-1] = trig_c;

  pm_out_stage #(.W(STAGE_W), .REG(REG_OUT)) i_stage (
    .clk(clk), .rst_n(rst_n), .d(stage_d), .q(stage_q)
  );
  assign adc_trig = stage_q[STAGE_W-1];

  // R9: crystal pins go analog while the oscillator control is low
  p_xtal_claim_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !osc32_run |-> (res[PIN_XT0].owner == OWN_XTAL && res[PIN_XT1].owner == OWN_XTAL));
  // R6: debug clock pin is an input owned by debug
  p_dbg_clock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_active |-> (res[PIN_DC].owner == OWN_DEBUG && !res[PIN_DC].oe));
  // R11: a trigger is only taken from a GPIO input pin
  p_trig_input_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trig_c |-> (res[PIN_TRIG].owner == OWN_GPIO && !res[PIN_TRIG].oe));
  // R7: the receive slot never drives
  p_i2s_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (i2s_en && !i2s_loc) |-> (res[I2S_BASE0+I2S_RX_SLOT].owner == OWN_I2S &&
                              !res[I2S_BASE0+I2S_RX_SLOT].oe));
endmodule

// File: tb/test_pin_func_arbiter.sv
module test_pin_func_arbiter;
  localparam int N = 24;
  localparam int RW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] gpio_dir, gpio_sel, gpio_dout;
  logic [N-1:0] per_a_req, per_a_out, per_a_oe, per_b_req, per_b_out, per_b_oe;
  logic prio_b_p1, dbg_active, dbg_dd_oe, dbg_dd_out;
  logic [7:0] adc_ana_en;
  logic i2s_en, i2s_loc, i2s_sck_out, i2s_sck_oe, i2s_ws_out, i2s_ws_oe, i2s_tx_out, i2s_tx_oe;
  logic [3*RW-1:0] radio_cfg;
  logic [2:0] radio_stat;
  logic osc32_run, adc_trig_en, trig_pin_in;
  logic [N-1:0] pin_out, pin_oe, pin_ana;
  logic [N*3-1:0] pin_owner;
  logic adc_trig;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pin_func_arbiter i_pin_func_arbiter (.*);

  function automatic logic [5:0] exp_pin(int i);
    logic po, pe;
    int s;
    if ((i == 19 || i == 20) && !osc32_run) return {3'd6, 3'b001};
    if (i == 17 && dbg_active) return {3'd3, dbg_dd_oe, dbg_dd_out, 1'b0};
    if (i == 18 && dbg_active) return {3'd3, 3'b000};
    s = -1;
    if (i2s_en && !i2s_loc && i >= 2 && i <= 5) s = i - 2;
    if (i2s_en && i2s_loc && i >= 12 && i <= 15) s = i - 12;
    case (s)
      0: return {3'd4, i2s_sck_oe, i2s_sck_out, 1'b0};
      1: return {3'd4, i2s_ws_oe, i2s_ws_out, 1'b0};
      2: return {3'd4, 3'b000};
      3: return {3'd4, i2s_tx_oe, i2s_tx_out, 1'b0};
      default: ;
    endcase
    if (i >= 13 && i <= 15 && !i2s_en && radio_cfg[(i-13)*RW +: RW] != 0)
      return {3'd5, 1'b1, radio_stat[i-13], 1'b0};
    if (i < 8 && adc_ana_en[i]) return {3'd2, 3'b001};
    if (gpio_sel[i]) begin
      if (per_a_req[i] && per_b_req[i]) begin
        if (i >= 8 && i <= 15 && prio_b_p1) begin po = per_b_out[i]; pe = per_b_oe[i]; end
        else begin po = per_a_out[i]; pe = per_a_oe[i]; end
      end else if (per_a_req[i]) begin po = per_a_out[i]; pe = per_a_oe[i]; end
      else if (per_b_req[i]) begin po = per_b_out[i]; pe = per_b_oe[i]; end
      else begin po = 1'b0; pe = 1'b0; end
      return {3'd1, pe, po, 1'b0};
    end
    return {3'd0, gpio_dir[i], gpio_dout[i], 1'b0};
  endfunction

  function automatic string tag_of(int i, logic [2:0] own);
    case (own)
      3'd1: return (i >= 8 && i <= 15 && per_a_req[i] && per_b_req[i]) ? "R4" : "R3";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic [5:0] e;
    for (int i = 0; i < N; i++) begin
      e = exp_pin(i);
      chk($sformatf("%s/R10 pin %0d", tag_of(i, e[5:3]), i),
          {2'b0, pin_owner[i*3 +: 3], pin_oe[i], pin_out[i], pin_ana[i]}, {2'b0, e});
    end
    chk("R11 trigger", {7'b0, adc_trig},
        {7'b0, adc_trig_en & ~gpio_sel[16] & ~gpio_dir[16] & trig_pin_in});
  endtask

  task automatic clear_in();
    {gpio_dir, gpio_sel, gpio_dout} = '0;
    {per_a_req, per_a_out, per_a_oe, per_b_req, per_b_out, per_b_oe} = '0;
    {prio_b_p1, dbg_active, dbg_dd_oe, dbg_dd_out, adc_ana_en} = '0;
    {i2s_en, i2s_loc, i2s_sck_out, i2s_sck_oe, i2s_ws_out, i2s_ws_oe, i2s_tx_out, i2s_tx_oe} = '0;
    radio_cfg = '0; radio_stat = '0;
    osc32_run = 1'b1; adc_trig_en = 1'b0; trig_pin_in = 1'b0;
  endtask

  task automatic rand_in();
    gpio_dir = $urandom; gpio_sel = $urandom; gpio_dout = $urandom;
    per_a_req = $urandom; per_a_out = $urandom; per_a_oe = $urandom;
    per_b_req = $urandom; per_b_out = $urandom; per_b_oe = $urandom;
    prio_b_p1 = $urandom; dbg_active = $urandom; dbg_dd_oe = $urandom; dbg_dd_out = $urandom;
    adc_ana_en = 8'($urandom) & 8'($urandom);
    i2s_en = ($urandom % 3 == 0); i2s_loc = $urandom;
    {i2s_sck_out, i2s_sck_oe, i2s_ws_out, i2s_ws_oe, i2s_tx_out, i2s_tx_oe} = 6'($urandom);
    for (int k = 0; k < 3; k++) radio_cfg[k*RW +: RW] = ($urandom % 2) ? RW'($urandom) : '0;
    radio_stat = $urandom; osc32_run = $urandom;
    adc_trig_en = $urandom; trig_pin_in = $urandom;
  endtask

  // apply at a falling edge, check at the next falling edge (one register)
  task automatic step();
    @(negedge clk);
    check_all();
  endtask

  initial begin
    void'($urandom(32'd2024));
    clear_in();
    gpio_dir = '1; gpio_dout = '1; adc_trig_en = 1'b1; trig_pin_in = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset out", {pin_out[7:0]}, 8'h00);
    chk("R1 reset oe", {pin_oe[7:0] | pin_oe[15:8] | pin_oe[23:16]}, 8'h00);
    chk("R1 reset owner", 8'(|pin_owner), 8'h00);
    chk("R1 reset trig", {7'b0, adc_trig}, 8'h00);
    rst_n = 1'b1;
    step();
    // R1: latency, change before edge is not yet visible
    @(negedge clk); gpio_dout = '0; #2;
    chk("R1 latency hold", pin_out[7:0], 8'hFF);
    @(negedge clk); check_all();
    // R9: crystal pins under full configuration
    gpio_sel = '1; gpio_dir = '1; per_a_req = '1; per_a_oe = '1; osc32_run = 1'b0;
    step();
    // R7 / R8: I2S on location 1 blocks radio, radio on with I2S off
    clear_in(); radio_cfg = {RW'(1), RW'(2), RW'(3)}; radio_stat = 3'b101; step();
    i2s_en = 1'b1; i2s_loc = 1'b0; i2s_sck_oe = 1'b1; i2s_sck_out = 1'b1; step();
    i2s_loc = 1'b1; i2s_tx_oe = 1'b1; i2s_tx_out = 1'b1; step();
    // R4: port-1 tie with both priority values, port-0 tie
    clear_in(); gpio_sel = '1; per_a_req = '1; per_b_req = '1;
    per_a_out = 24'h00FF00; per_a_oe = '1; per_b_out = 24'hFF00FF; per_b_oe = '0;
    prio_b_p1 = 1'b0; step();
    prio_b_p1 = 1'b1; step();
    // R5 / R6: ADC overrides select, debug takes its pins
    adc_ana_en = 8'hA5; dbg_active = 1'b1; dbg_dd_oe = 1'b1; dbg_dd_out = 1'b1; step();
    for (int n = 0; n < 400; n++) begin
      @(negedge clk); rand_in();
      step();
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule